// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Half-Word Writes

This block is an 18-bit-wide synchronous static memory with a built-in two-bit burst sequencer. On each rising clock edge it captures the address, the bus data, chip enable, the two half-word write enables, the advance input and two address-load strobes. One strobe is meant for a processor and the other for a cache controller. Either strobe loads a fresh start address. After that the advance input walks the two low address bits through an interleaved four-beat order, so a cache line can be filled or drained from a single address.

Read data is held in an output register and placed on a shared bidirectional data bus. An output-enable input that is not clocked controls the bus, which makes turnaround a matter of timing rather than cycles. A write completes at the edge that samples it. The upper and lower 9-bit halves each have their own enable. The depth is 2^ADDR_W words; ADDR_W = 16 gives the full 65,536-word array, and the default build is smaller.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high at a rising edge, the output data register is cleared to zero and the burst start address and step count are cleared. Directly after reset, with `oe_n` low, `dq` reads 0.
- R2: At an edge where `ce_n` is low and either `pstb_n` or `cstb_n` is low, `addr` becomes the burst start address and the step count goes to 0. On a read cycle, the addressed word is on `dq` right after that same edge when `oe_n` is low.
- R3: At an edge where `ce_n` is high, both strobes are ignored. Without an advance, the selected address stays the same.
- R4: When both strobes are low with `ce_n` low, the processor strobe takes priority. A cycle loaded by `pstb_n` is always a read: the write enables are ignored and memory is unchanged.
- R5: At an edge with `adv_n` low and no load, the step count increments modulo 4. The low two address bits equal the start low bits XOR the count (0,1,2,3). After four steps the address is back at the start. The upper address bits never change during a burst.
- R6: At an edge with no load and `adv_n` high, the selected address is held. A write in that cycle goes to the held address.
- R7: `lwe_n` low writes bus bits 8:0 and `uwe_n` low writes bus bits 17:9. Each enable works independently of the other, and the unselected half keeps its contents.
- R8: A write takes effect at the edge that samples it, with no further cycles. The output register keeps its value on write cycles, and the next read of that address returns the new data.
- R9: With `oe_n` high, the block releases `dq` at once, without waiting for a clock edge. With `oe_n` low, it drives the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| ce_n | input | 1 | Chip enable, active low, gates the strobes |
| pstb_n | input | 1 | Processor address-load strobe, active low, read-only cycle |
| cstb_n | input | 1 | Controller address-load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lwe_n | input | 1 | Lower half write enable (bits 8:0), active low |
| uwe_n | input | 1 | Upper half write enable (bits 17:9), active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| dq | inout | 18 | Shared data bus, write data in, read data out |

## Verification
On every cycle, the assertions check the following. The address is held on cycles without a strobe. A strobe is ignored when chip enable is off. Four advances return to the start address, and the upper address bits stay fixed. A processor-loaded cycle never writes. A half write leaves the other half intact. The output register takes the stored word on each read cycle. Other behaviours can only be shown by the bench scenarios: the complete interleaved orders from each of the four start offsets, data written and read back over the shared bus, the immediate release of the bus when output enable goes high, and the reset value seen at the pins.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int HALF_W  = 9;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int STEP_W  = 2;
    localparam int NHALVES = WORD_W / HALF_W;

    // Decoded intent of one clock cycle
    typedef struct packed {
        logic load;   // a strobe loads a new start address
        logic pload;  // the load came from the processor strobe
        logic adv;    // step the burst count (only without a load)
        logic wr_lo;  // write bits 8:0
        logic wr_hi;  // write bits 17:9
    } cyc_ctl_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_STEP = 2'd1,
        SRC_LOAD = 2'd2
    } addr_src_e;

    // Interleaved burst order: start low bits XOR the step count
    function automatic logic [STEP_W-1:0] step_low(
        input logic [STEP_W-1:0] start_lo,
        input logic [STEP_W-1:0] count
    );
        return start_lo ^ count;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              lwe_n,
    input  logic              uwe_n,
    output cyc_ctl_t          ctl,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int HI_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] base_q, base_n;
    logic [STEP_W-1:0] cnt_q, cnt_n;
    addr_src_e         src;
    logic [2:0]        age_q;

    always_comb begin
        ctl.pload = !ce_n && !pstb_n;
        ctl.load  = !ce_n && (!pstb_n || !cstb_n);
        ctl.adv   = !adv_n && !ctl.load;
        ctl.wr_lo = !lwe_n && !ctl.pload;
        ctl.wr_hi = !uwe_n && !ctl.pload;
    end

    always_comb begin
        if (ctl.load)     src = SRC_LOAD;
        else if (ctl.adv) src = SRC_STEP;
        else              src = SRC_HOLD;
    end

    always_comb begin
        base_n = base_q;
        cnt_n  = cnt_q;
        case (src)
            SRC_LOAD: begin
                base_n = addr;
                cnt_n  = '0;
            end
            SRC_STEP: cnt_n = cnt_q + 1'b1;
            default:  ;
        endcase
    end

    // Address used by this cycle's access, selected at this edge
    assign eff_addr = {base_n[ADDR_W-1:STEP_W], step_low(base_n[STEP_W-1:0], cnt_n)};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
        end
    end

    // cycles since reset, saturating; bounds the history the checks look at
    always_ff @(posedge clk) begin
        if (rst)               age_q <= '0;
        else if (age_q != 3'd4) age_q <= age_q + 3'd1;
    end

    // R3
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 3'd0 && ce_n && adv_n) |-> eff_addr == $past(eff_addr));

    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 3'd0 && pstb_n && cstb_n && adv_n) |-> eff_addr == $past(eff_addr));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 3'd0 && !ctl.load) |->
            eff_addr[ADDR_W-1:STEP_W] == $past(eff_addr[ADDR_W-1:STEP_W]));

    // R5
    wrap_four_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd4 && ctl.adv && $past(ctl.adv) && $past(ctl.adv, 2) && $past(ctl.adv, 3))
            |-> eff_addr == $past(eff_addr, 4));

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = base_q[ADDR_W-1:STEP_W];

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  cyc_ctl_t          ctl,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0]  mem [DEPTH];
    logic [NHALVES-1:0] we;
    logic               any_wr;

    assign we     = {ctl.wr_hi, ctl.wr_lo};
    assign any_wr = |we;

    always_ff @(posedge clk) begin
        for (int h = 0; h < NHALVES; h++) begin
            if (we[h]) mem[addr][h*HALF_W +: HALF_W] <= din[h*HALF_W +: HALF_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          dout <= '0;
        else if (!any_wr) dout <= mem[addr];
    end

    // R4
    pread_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pload |-> !ctl.wr_lo && !ctl.wr_hi);

    // R7
    upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.wr_lo && !ctl.wr_hi) |=>
            mem[$past(addr)][WORD_W-1:HALF_W] == $past(mem[addr][WORD_W-1:HALF_W]));

    // R7
    lower_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.wr_hi && !ctl.wr_lo) |=>
            mem[$past(addr)][HALF_W-1:0] == $past(mem[addr][HALF_W-1:0]));

    // R2
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !any_wr |=> dout == $past(mem[addr]));

    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> $stable(dout));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              lwe_n,
    input  logic              uwe_n,
    input  logic              oe_n,
    inout  wire  [17:0]       dq
);
    cyc_ctl_t          ctl;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] rd_word;

    bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .ce_n     (ce_n),
        .pstb_n   (pstb_n),
        .cstb_n   (cstb_n),
        .adv_n    (adv_n),
        .lwe_n    (lwe_n),
        .uwe_n    (uwe_n),
        .ctl      (ctl),
        .eff_addr (eff_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk  (clk),
        .rst  (rst),
        .addr (eff_addr),
        .ctl  (ctl),
        .din  (dq),
        .dout (rd_word)
    );

    // bus driven from the output register, released as soon as oe_n rises
    assign dq = oe_n ? 'z : rd_word;

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    typedef enum logic [2:0] {
        K_P = 3'd0,  // processor strobe load
        K_C = 3'd1,  // controller strobe load
        K_A = 3'd2,  // advance
        K_H = 3'd3,  // hold
        K_N = 3'd4,  // controller strobe with chip disabled
        K_B = 3'd5   // both strobes
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [9:0]  a;
        logic        lw;
        logic        uw;
        logic [17:0] d;
    } row_t;

    localparam int NROWS = 39;
    localparam row_t TBL [NROWS] = '{
        '{K_C, 10'h040, 1'b1, 1'b1, 18'h15A01},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h0F302},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h3C043},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h00F84},
        '{K_C, 10'h1A8, 1'b1, 1'b1, 18'h2468A},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h13579},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h30C0E},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h1C0DE},
        '{K_P, 10'h041, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_P, 10'h042, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_C, 10'h043, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_P, 10'h1AA, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_C, 10'h040, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_B, 10'h040, 1'b1, 1'b1, 18'h3FFFF},
        '{K_H, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_C, 10'h041, 1'b1, 1'b0, 18'h2AB55},
        '{K_H, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_C, 10'h042, 1'b0, 1'b1, 18'h0A5F0},
        '{K_H, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_N, 10'h1A9, 1'b0, 1'b0, 18'h0},
        '{K_H, 10'h000, 1'b1, 1'b1, 18'h12345},
        '{K_H, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b1, 1'b1, 18'h06789},
        '{K_H, 10'h000, 1'b0, 1'b0, 18'h0},
        '{K_A, 10'h000, 1'b0, 1'b0, 18'h0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          ce_n, pstb_n, cstb_n, adv_n, lwe_n, uwe_n, oe_n;
    logic          drv_en;
    logic [17:0]   drv_val;
    wire  [17:0]   dq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [17:0] mdl_mem [int];
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic [17:0]   m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dq = drv_en ? drv_val : 'z;
    for (genvar i = 0; i < 18; i++) begin : g_pu
        pullup (dq[i]);
    end

    burst_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .pstb_n(pstb_n),
        .cstb_n(cstb_n), .adv_n(adv_n), .lwe_n(lwe_n), .uwe_n(uwe_n),
        .oe_n(oe_n), .dq(dq)
    );

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] mrd(input logic [AW-1:0] a);
        if (mdl_mem.exists(int'(a))) return mdl_mem[int'(a)];
        return 18'h0;
    endfunction

    // drive one table row, update the model, return whether it is a read
    task automatic apply(input row_t r, output bit is_rd, output string tag);
        bit ce, ld, pld, adv, wl, wh;
        logic [AW-1:0] eff;
        logic [17:0] w;
        ce  = (r.kind != K_N) && (r.kind != K_A) && (r.kind != K_H);
        ld  = (r.kind == K_P) || (r.kind == K_C) || (r.kind == K_B);
        pld = (r.kind == K_P) || (r.kind == K_B);
        adv = (r.kind == K_A);
        wl  = r.lw && !pld;
        wh  = r.uw && !pld;
        if (ld) begin
            m_base = r.a;
            m_cnt  = 2'd0;
        end else if (adv) begin
            m_cnt = m_cnt + 2'd1;
        end
        eff = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
        is_rd = !(wl || wh);
        if (!is_rd) begin
            w = mrd(eff);
            if (wl) w[8:0]  = r.d[8:0];
            if (wh) w[17:9] = r.d[17:9];
            mdl_mem[int'(eff)] = w;
        end else begin
            m_out = mrd(eff);
        end
        case (r.kind)
            K_P, K_C: tag = "R2";
            K_A:      tag = "R5";
            K_B:      tag = "R4";
            K_N:      tag = "R3";
            default:  tag = "R6 R7 R8";
        endcase
        addr    = r.a;
        ce_n    = !ce;
        pstb_n  = !((r.kind == K_P) || (r.kind == K_B));
        cstb_n  = !((r.kind == K_C) || (r.kind == K_B) || (r.kind == K_N));
        adv_n   = !adv;
        lwe_n   = !r.lw;
        uwe_n   = !r.uw;
        oe_n    = !is_rd;
        drv_en  = !is_rd;
        drv_val = r.d;
    endtask

    initial begin
        int n;
        n = 0;
        while (!done && n < 5000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit    rd;
        string tg;
        rst = 1'b1; addr = '0; ce_n = 1'b1; pstb_n = 1'b1; cstb_n = 1'b1;
        adv_n = 1'b1; lwe_n = 1'b1; uwe_n = 1'b1; oe_n = 1'b1;
        drv_en = 1'b0; drv_val = '0;
        m_base = '0; m_cnt = '0; m_out = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst  = 1'b0;
        oe_n = 1'b0;
        #1;
        // R1: output register cleared by reset
        chk("R1", dq, 18'h0);

        for (int i = 0; i < NROWS; i++) begin
            apply(TBL[i], rd, tg);
            @(posedge clk);
            @(negedge clk);
            if (rd) chk(tg, dq, m_out);
        end

        // R9: release without a clock edge, bus then shows the pull-up
        drv_en = 1'b0;
        ce_n = 1'b1; pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
        lwe_n = 1'b1; uwe_n = 1'b1;
        #2;
        oe_n = 1'b1;
        #1;
        chk("R9", dq, 18'h3FFFF);
        oe_n = 1'b0;
        #1;
        chk("R9", dq, m_out);

        // R1: mid-run reset clears the output register again
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", dq, 18'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule